// File: doc/BRIEF.md
# Interrupt Source Controller

This block is the source layer of a two-level interrupt scheme. It watches a set of interrupt inputs. Each input has its own entry: a destination server, a priority and a saved priority, plus a few bits of retry state. From these it issues presentation requests that a separate presenter takes up. The presenter answers through three strobes. A reject strobe means the presenter turned a request down. An end-of-interrupt strobe means handling is complete. A resend strobe asks the block to offer anything it holds back once more.

The type of each source is fixed by a parameter mask. A message source treats a high input cycle as one trigger event. It remembers a trigger that arrived while it was masked, and it remembers a refusal, so either can be replayed later. A level source follows its line. It keeps a sent flag, so a line that stays high is offered once and offered again only after a reject or an EOI followed by a resend, or after a configuration write. Source numbers on the presenter side are a base offset plus the local index. The all-ones priority means masked.

Top module: `isc_source_ctrl`

## Requirements
- R1: Reset sets every entry to server 0 with priority and saved priority both all ones, and clears all state bits. The status read port encodes the bits as follows: bit0 is asserted, bit1 is sent, bit2 is rejected and bit3 is masked-pending.
- R2: A configuration write stores server, priority and saved priority for the addressed entry. The read port returns them without delay.
- R3: A message trigger on a masked source sets masked-pending and presents nothing. No presentation ever carries the masked priority.
- R4: A message trigger on an unmasked source presents once, two clocks later, with number BASE+index and the entry's priority and server.
- R5: A configuration write that unmasks a message source with masked-pending set presents that source and clears masked-pending. Without masked-pending the same write presents nothing.
- R6: A level source's asserted bit follows its line. A rising line on an unmasked, unsent source presents once and sets sent. A held line presents nothing more, and a new rise while sent is still set presents nothing.
- R7: A configuration write on a level source runs the level check, so an asserted, unsent source becomes presented once it is unmasked.
- R8: A reject sets rejected on a message source and clears sent on a level source. Neither case presents anything by itself.
- R9: An EOI clears sent on a level source and leaves a message source's state unchanged.
- R10: A resend visits every source in turn. A level source that is asserted and unsent is presented again. A message source with rejected set has the bit cleared, and it is presented again only if unmasked.
- R11: At most one presentation goes out per cycle. Requests pending together go out on consecutive cycles, lowest index first, each exactly once. The resend walk pauses in any cycle that issues a presentation.
- R12: A reject or EOI whose number lies outside BASE..BASE+N_SRC-1 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_SRC | Source inputs: trigger pulses for message sources, lines for level sources |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Local index of the entry being written |
| cfg_server | input | SRV_W | Destination server to store |
| cfg_prio | input | PRIO_W | Priority to store (all ones masks the source) |
| cfg_saved | input | PRIO_W | Saved priority to store |
| rej_valid | input | 1 | Reject strobe from the presenter |
| rej_num | input | NUM_W | Global number of the rejected source |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number being completed |
| rsnd_valid | input | 1 | Resend request |
| pres_valid | output | 1 | Presentation request, one cycle per request |
| pres_num | output | NUM_W | Global number of the presented source |
| pres_server | output | SRV_W | Destination server |
| pres_prio | output | PRIO_W | Priority of the presented source |
| rd_idx | input | IDX_W | Entry selected for readback |
| rd_server | output | SRV_W | Server of the selected entry |
| rd_prio | output | PRIO_W | Priority of the selected entry |
| rd_saved | output | PRIO_W | Saved priority of the selected entry |
| rd_status | output | 4 | State bits of the selected entry |

## Verification
Single message triggers on masked and unmasked sources separate the immediate path from the deferred path. Bursts of several simultaneous triggers, both directed and drawn at random over the message sources, show whether arbitration keeps lowest-first order and loses or repeats no request. Level lines are raised, held, dropped and raised again around rejects, EOIs and resends, which shows whether the sent flag, rather than the line alone, controls re-presentation. Strobes just below and just above the number window show that out-of-range numbers are ignored.

// File: rtl/isc_pkg.sv
package isc_pkg;

  // Per-entry state bits; packed order gives the readback encoding (bit3..bit0)
  typedef struct packed {
    logic mpend;
    logic rejected;
    logic sent;
    logic asserted;
  } isc_stat_t;

  function automatic logic num_in_window(input int unsigned num,
                                         input int unsigned base,
                                         input int unsigned count);
    return (num >= base) && (num < base + count);
  endfunction

  function automatic int unsigned num_to_local(input int unsigned num,
                                               input int unsigned base);
    return num - base;
  endfunction

  function automatic int unsigned local_to_num(input int unsigned idx,
                                               input int unsigned base);
    return idx + base;
  endfunction

endpackage

// File: rtl/isc_src_slot.sv
module isc_src_slot import isc_pkg::*; #(
  parameter bit IS_LEVEL = 1'b0,
  parameter int SRV_W    = 4,
  parameter int PRIO_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  input  logic              cfg_we_i,
  input  logic [SRV_W-1:0]  cfg_server_i,
  input  logic [PRIO_W-1:0] cfg_prio_i,
  input  logic [PRIO_W-1:0] cfg_saved_i,
  input  logic              rej_i,
  input  logic              eoi_i,
  input  logic              scan_i,
  input  logic              grant_i,
  output logic              want_o,
  output logic [SRV_W-1:0]  server_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic [PRIO_W-1:0] saved_o,
  output isc_stat_t         stat_o
);
  localparam logic [PRIO_W-1:0] MASKED = '1;

  logic [SRV_W-1:0]  server_q;
  logic [PRIO_W-1:0] prio_q, saved_q;
  logic              unmasked, new_unmasked;

  assign unmasked     = (prio_q != MASKED);
  assign new_unmasked = (cfg_prio_i != MASKED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      server_q <= '0;
      prio_q   <= MASKED;
      saved_q  <= MASKED;
    end else if (cfg_we_i) begin
      server_q <= cfg_server_i;
      prio_q   <= cfg_prio_i;
      saved_q  <= cfg_saved_i;
    end
  end

  assign server_o = server_q;
  assign prio_o   = prio_q;
  assign saved_o  = saved_q;

  generate
    if (IS_LEVEL) begin : g_level
      logic asserted_q, sent_q, req_q;
      logic line_chg, check_ok, req_d, sent_d;
      logic unused_level;

      assign unused_level = new_unmasked;
      assign line_chg = (line_i != asserted_q);
      assign check_ok = unmasked & asserted_q & ~sent_q;
      assign want_o   = req_q & check_ok;
      // a pending check that fails is dropped; one that passes waits for its grant
      assign req_d    = (req_q & check_ok & ~grant_i) | line_chg | cfg_we_i | scan_i;
      assign sent_d   = (sent_q & ~(rej_i | eoi_i)) | grant_i;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          asserted_q <= 1'b0;
          sent_q     <= 1'b0;
          req_q      <= 1'b0;
        end else begin
          asserted_q <= line_i;
          sent_q     <= sent_d;
          req_q      <= req_d;
        end
      end

      assign stat_o = '{mpend: 1'b0, rejected: 1'b0, sent: sent_q, asserted: asserted_q};

      a_r6_sent_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sent_q) |-> $past(asserted_q));
    end else begin : g_msg
      logic rej_q, mpend_q, req_q;
      logic trig_m, trig_u, mp_any, replay, replay_rs;
      logic unused_msg;

      assign unused_msg = eoi_i;
      assign trig_m    = line_i & ~unmasked;
      assign trig_u    = line_i & unmasked;
      // a request left waiting when the source got masked is folded into masked-pending
      assign mp_any    = mpend_q | trig_m | (req_q & ~unmasked);
      assign replay    = cfg_we_i & new_unmasked & mp_any;
      assign replay_rs = scan_i & rej_q & unmasked;
      assign want_o    = req_q & unmasked;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rej_q   <= 1'b0;
          mpend_q <= 1'b0;
          req_q   <= 1'b0;
        end else begin
          rej_q   <= rej_i | (rej_q & ~scan_i);
          mpend_q <= mp_any & ~replay;
          req_q   <= (req_q & unmasked & ~grant_i) | trig_u | replay | replay_rs;
        end
      end

      assign stat_o = '{mpend: mpend_q, rejected: rej_q, sent: 1'b0, asserted: 1'b0};

      a_r8_rej_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rej_q) |-> $past(rej_i));
      a_r5_mpend_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mpend_q) |-> $past(cfg_we_i));
    end
  endgenerate

endmodule

// File: rtl/isc_pick.sv
module isc_pick #(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] want_i,
  output logic [N_SRC-1:0] grant_o,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  // fixed priority: the lowest index with a request wins
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (want_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  always_comb begin
    grant_o = '0;
    if (any_o) grant_o[idx_o] = 1'b1;
  end

endmodule

// File: rtl/isc_scan.sv
module isc_scan #(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stall_i,
  output logic [N_SRC-1:0] hit_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_SRC - 1);

  logic             on_q;
  logic [IDX_W-1:0] idx_q;
  logic             visit;

  assign visit = on_q & ~stall_i & ~start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      idx_q <= '0;
    end else if (start_i) begin
      on_q  <= 1'b1;
      idx_q <= '0;
    end else if (visit) begin
      if (idx_q == LAST) on_q <= 1'b0;
      else               idx_q <= idx_q + 1'b1;
    end
  end

  always_comb begin
    hit_o = '0;
    if (visit) hit_o[idx_q] = 1'b1;
  end

endmodule

// File: rtl/isc_source_ctrl.sv
module isc_source_ctrl import isc_pkg::*; #(
  parameter int N_SRC  = 8,
  parameter int SRV_W  = 4,
  parameter int PRIO_W = 8,
  parameter int NUM_W  = 12,
  parameter int unsigned BASE = 16,
  parameter logic [N_SRC-1:0] LEVEL_MASK = N_SRC'(8'hF0),
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_in,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [SRV_W-1:0]  cfg_server,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic [PRIO_W-1:0] cfg_saved,
  input  logic              rej_valid,
  input  logic [NUM_W-1:0]  rej_num,
  input  logic              eoi_valid,
  input  logic [NUM_W-1:0]  eoi_num,
  input  logic              rsnd_valid,
  output logic              pres_valid,
  output logic [NUM_W-1:0]  pres_num,
  output logic [SRV_W-1:0]  pres_server,
  output logic [PRIO_W-1:0] pres_prio,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [SRV_W-1:0]  rd_server,
  output logic [PRIO_W-1:0] rd_prio,
  output logic [PRIO_W-1:0] rd_saved,
  output logic [3:0]        rd_status
);
  localparam logic [PRIO_W-1:0] MASKED = '1;

  logic [N_SRC-1:0]  cfg_hit, rej_hit, eoi_hit, scan_hit, want, grant;
  logic [SRV_W-1:0]  server [N_SRC];
  logic [PRIO_W-1:0] prio   [N_SRC];
  logic [PRIO_W-1:0] saved  [N_SRC];
  isc_stat_t         stat   [N_SRC];

  logic              rej_ok, eoi_ok, any_grant;
  logic [IDX_W-1:0]  rej_idx, eoi_idx, grant_idx;

  // strobe numbers to local indices; out-of-window numbers match no entry
  assign rej_ok  = rej_valid & num_in_window(32'(rej_num), BASE, N_SRC);
  assign eoi_ok  = eoi_valid & num_in_window(32'(eoi_num), BASE, N_SRC);
  assign rej_idx = IDX_W'(num_to_local(32'(rej_num), BASE));
  assign eoi_idx = IDX_W'(num_to_local(32'(eoi_num), BASE));

  generate
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
      assign cfg_hit[i] = cfg_we & (cfg_idx == IDX_W'(i));
      assign rej_hit[i] = rej_ok & (rej_idx == IDX_W'(i));
      assign eoi_hit[i] = eoi_ok & (eoi_idx == IDX_W'(i));

      isc_src_slot #(
        .IS_LEVEL (LEVEL_MASK[i]),
        .SRV_W    (SRV_W),
        .PRIO_W   (PRIO_W)
      ) u_slot (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_i       (irq_in[i]),
        .cfg_we_i     (cfg_hit[i]),
        .cfg_server_i (cfg_server),
        .cfg_prio_i   (cfg_prio),
        .cfg_saved_i  (cfg_saved),
        .rej_i        (rej_hit[i]),
        .eoi_i        (eoi_hit[i]),
        .scan_i       (scan_hit[i]),
        .grant_i      (grant[i]),
        .want_o       (want[i]),
        .server_o     (server[i]),
        .prio_o       (prio[i]),
        .saved_o      (saved[i]),
        .stat_o       (stat[i])
      );
    end
  endgenerate

  isc_pick #(.N_SRC(N_SRC)) u_pick (
    .want_i  (want),
    .grant_o (grant),
    .any_o   (any_grant),
    .idx_o   (grant_idx)
  );

  isc_scan #(.N_SRC(N_SRC)) u_scan (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (rsnd_valid),
    .stall_i (any_grant),
    .hit_o   (scan_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pres_valid  <= 1'b0;
      pres_num    <= '0;
      pres_server <= '0;
      pres_prio   <= '0;
    end else begin
      pres_valid <= any_grant;
      if (any_grant) begin
        pres_num    <= NUM_W'(local_to_num(32'(grant_idx), BASE));
        pres_server <= server[grant_idx];
        pres_prio   <= prio[grant_idx];
      end
    end
  end

  logic rd_ok;
  assign rd_ok = (32'(rd_idx) < N_SRC);

  always_comb begin
    rd_server = '0;
    rd_prio   = '0;
    rd_saved  = '0;
    rd_status = '0;
    if (rd_ok) begin
      rd_server = server[rd_idx];
      rd_prio   = prio[rd_idx];
      rd_saved  = saved[rd_idx];
      rd_status = stat[rd_idx];
    end
  end

  logic [IDX_W-1:0] pres_lidx;
  assign pres_lidx = IDX_W'(num_to_local(32'(pres_num), BASE));

  a_r3_masked_never_shown: assert property (@(posedge clk) disable iff (!rst_n)
    pres_valid |-> (pres_prio != MASKED));
  a_r12_pres_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    pres_valid |-> num_in_window(32'(pres_num), BASE, N_SRC));
  a_r11_scan_yields: assert property (@(posedge clk) disable iff (!rst_n)
    (|scan_hit) |-> !any_grant);
  a_r6_level_pres_marks_sent: assert property (@(posedge clk) disable iff (!rst_n)
    (pres_valid && LEVEL_MASK[pres_lidx]) |-> stat[pres_lidx].sent);

endmodule

// File: tb/isc_source_ctrl_test.sv
`timescale 1ns/1ps
module isc_source_ctrl_test;
  localparam int N = 8;
  localparam int BASE = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_in = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [3:0]  cfg_server = '0;
  logic [7:0]  cfg_prio = '0, cfg_saved = '0;
  logic        rej_valid = 1'b0, eoi_valid = 1'b0, rsnd_valid = 1'b0;
  logic [11:0] rej_num = '0, eoi_num = '0;
  logic        pres_valid;
  logic [11:0] pres_num;
  logic [3:0]  pres_server;
  logic [7:0]  pres_prio;
  logic [2:0]  rd_idx = '0;
  logic [3:0]  rd_server;
  logic [7:0]  rd_prio, rd_saved;
  logic [3:0]  rd_status;

  isc_source_ctrl uut (.*);

  always #4 clk = ~clk;

  typedef struct { int num; int prio; int srv; int cyc; } pres_t;
  pres_t pq[$];
  int ncyc = 0;
  int tests = 0, fails = 0;
  bit done = 0;
  int ep[4], es[4];

  always @(negedge clk) begin
    ncyc++;
    if (rst_n && pres_valid)
      pq.push_back('{int'(pres_num), int'(pres_prio), int'(pres_server), ncyc});
  end

  function automatic int exp_num(int idx);
    return BASE + idx;
  endfunction

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic cfg(int idx, int srv, int prio, int sv);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_server = 4'(srv); cfg_prio = 8'(prio); cfg_saved = 8'(sv);
    step(1);
    cfg_we = 0;
  endtask

  task automatic trig(logic [3:0] m);
    irq_in[3:0] = m; step(1); irq_in[3:0] = '0;
  endtask

  task automatic rej(int num);
    rej_valid = 1; rej_num = 12'(num); step(1); rej_valid = 0;
  endtask

  task automatic eoi(int num);
    eoi_valid = 1; eoi_num = 12'(num); step(1); eoi_valid = 0;
  endtask

  task automatic rsnd();
    rsnd_valid = 1; step(1); rsnd_valid = 0;
  endtask

  task automatic stat(string tag, int idx, int exp);
    rd_idx = 3'(idx); #1;
    check(tag, int'(rd_status), exp);
  endtask

  task automatic none(string tag);
    check({tag, " no presentation"}, pq.size(), 0);
    pq.delete();
  endtask

  task automatic pres(string tag, int num, int prio, int srv);
    pres_t p;
    tests++;
    if (pq.size() == 0) begin
      fails++;
      $display("FAIL %s: actual 0 presentations expected num %0d", tag, num);
    end else begin
      p = pq.pop_front();
      tests--;
      check({tag, " num"}, p.num, num);
      check({tag, " prio"}, p.prio, prio);
      check({tag, " server"}, p.srv, srv);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    step(3);
    // R1: reset values
    for (int i = 0; i < N; i++) begin
      rd_idx = 3'(i); #1;
      check("R1 prio", int'(rd_prio), 255);
      check("R1 saved", int'(rd_saved), 255);
      check("R1 server", int'(rd_server), 0);
      check("R1 status", int'(rd_status), 0);
    end
    rst_n = 1;
    step(4);
    none("R1 after reset");

    // R2: configure message sources
    for (int i = 0; i < 4; i++) begin
      ep[i] = 16 + i; es[i] = i + 1;
      cfg(i, es[i], ep[i], 32 + i);
    end
    for (int i = 0; i < 4; i++) begin
      rd_idx = 3'(i); #1;
      check("R2 server", int'(rd_server), es[i]);
      check("R2 prio", int'(rd_prio), ep[i]);
      check("R2 saved", int'(rd_saved), 32 + i);
    end
    step(3);
    none("R5 cfg without masked-pending");

    // R4
    trig(4'h4); step(3);
    pres("R4 single trigger", exp_num(2), ep[2], es[2]);
    none("R4 only once");

    // R3
    cfg(3, 4, 255, 35); trig(4'h8); step(3);
    none("R3 masked trigger");
    stat("R3 masked-pending", 3, 8);

    // R5
    ep[3] = 5;
    cfg(3, 4, 5, 35); step(3);
    pres("R5 replay", exp_num(3), 5, 4);
    stat("R5 cleared", 3, 0);
    cfg(3, 4, 5, 35); step(3);
    none("R5 repeat cfg");

    // R8 / R9 message
    rej(exp_num(2)); step(3);
    none("R8 msg reject");
    stat("R8 rejected set", 2, 4);
    eoi(exp_num(2)); step(2);
    stat("R9 msg eoi no effect", 2, 4);

    // R10 message replay
    rsnd(); step(14);
    pres("R10 msg resend", exp_num(2), ep[2], es[2]);
    none("R10 msg once");
    stat("R10 rejected cleared", 2, 0);

    rej(exp_num(1)); cfg(1, 2, 255, 33); rsnd(); step(14);
    none("R10 masked rejected");
    stat("R10 masked cleared", 1, 0);
    cfg(1, 2, ep[1], 33); step(3);
    none("R10 unmask after clear");

    // R6 level
    cfg(5, 2, 8, 0); step(2);
    irq_in[5] = 1; step(3);
    pres("R6 level rise", exp_num(5), 8, 2);
    stat("R6 asserted+sent", 5, 3);
    step(10);
    none("R6 held line");
    irq_in[5] = 0; step(2);
    stat("R6 follows line", 5, 2);
    irq_in[5] = 1; step(3);
    none("R6 rise while sent");
    stat("R6 reasserted", 5, 3);

    // R8 level
    rej(exp_num(5)); step(10);
    none("R8 level reject");
    stat("R8 sent cleared", 5, 1);

    // R10 level
    rsnd(); step(14);
    pres("R10 level resend", exp_num(5), 8, 2);
    stat("R10 level sent", 5, 3);

    // R9 level
    eoi(exp_num(5)); step(5);
    none("R9 level eoi");
    stat("R9 sent cleared", 5, 1);

    // R12 out of range
    rsnd(); step(14);
    pres("R12 setup", exp_num(5), 8, 2);
    eoi(BASE + N); eoi(BASE - 1); rej(BASE - 1); rej(BASE + N); step(3);
    none("R12 out-of-range");
    stat("R12 level untouched", 5, 3);
    for (int i = 0; i < 4; i++) stat("R12 msg untouched", i, 0);

    // R7
    irq_in[6] = 1; step(3);
    none("R7 masked level");
    stat("R7 asserted", 6, 1);
    cfg(6, 1, 3, 0); step(3);
    pres("R7 cfg check", exp_num(6), 3, 1);
    stat("R7 sent", 6, 3);

    // R11 simultaneous
    trig(4'hF); step(7);
    check("R11 count", pq.size(), 4);
    if (pq.size() == 4) begin
      for (int i = 0; i < 4; i++) begin
        if (i > 0) check("R11 consecutive", pq[i].cyc, pq[0].cyc + i);
      end
      for (int i = 0; i < 4; i++) pres("R11 order", exp_num(i), ep[i], es[i]);
    end
    pq.delete();

    // R4/R11 random bursts
    for (int it = 0; it < 40; it++) begin
      logic [3:0] m;
      int k;
      k = int'($urandom_range(3, 0));
      ep[k] = int'($urandom_range(254, 0));
      es[k] = int'($urandom_range(15, 0));
      cfg(k, es[k], ep[k], 0);
      m = 4'($urandom_range(15, 1));
      trig(m); step(7);
      for (int i = 0; i < 4; i++)
        if (m[i]) pres("R11 random burst", exp_num(i), ep[i], es[i]);
      none("R11 random extra");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule